// File: doc/BRIEF.md
# Configuration Memory Boot Loader

After every reset, this block reads the first ten bytes of an external configuration memory, one byte at a time, through a request/acknowledge byte reader. The serial bus that sits behind that reader is handled elsewhere. The first two bytes must form a fixed signature. When they do, and all ten bytes arrive in time, the block takes the device identity fields and the power fields from the image. In every other case it presents built-in defaults.

The outputs are vendor ID, product ID, device release, configuration attributes and maximum power, together with a flag that says whether the image was used. A ready flag tells the USB attach logic when it may connect. Ready stays low until loading has ended. It rises on the same edge on which the final field values appear, and after that every output holds still until the next reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is held, ready_o and img_valid_o are 0, the field outputs show the defaults listed in R5, and rd_req_o is 1 with rd_addr_o = 0.
- R2: The block reads bytes at ascending addresses starting at 0, one request at a time, and never requests an address above 9. While a request waits for rd_ack_i, rd_req_o stays high and rd_addr_o does not change. A transfer takes place on a clock edge where both rd_req_o and rd_ack_i are 1.
- R3: The signature is byte 0 = 0x7B and byte 1 = 0x06, which is the 16-bit little-endian word 0x067B. If byte 0 does not match, loading ends after that single read. If byte 1 does not match, loading ends after two reads.
- R4: When the signature matches and all ten bytes are transferred, img_valid_o = 1 and the outputs are: vid_o = {byte3, byte2}, pid_o = {byte5, byte4}, rel_o = {byte7, byte6}, attr_o = byte8, max_pwr_o = byte9.
- R5: When the image is not used, img_valid_o = 0 and the outputs are vid_o = 0x067B, pid_o = 0x2507, rel_o = 0x0100, attr_o = 0xC0 and max_pwr_o = 0x32.
- R6: If a request is held for TMO_CYCLES clock cycles without an acknowledge, loading stops and the defaults of R5 are used. This applies to the first byte and to any later byte. Fields already received are discarded.
- R7: ready_o is 0 while loading is in progress. It rises on the edge on which the final outputs appear and stays at 1 until reset. While ready_o is 1, rd_req_o is 0 and no output changes.
- R8: An rd_ack_i pulse that arrives while no request is pending has no effect on any output.
- R9: Every reset starts detection again from address 0. This includes a reset that arrives in the middle of a load, and the result then reflects the memory contents read after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_o | output | 1 | Byte read request to the memory reader |
| rd_addr_o | output | ADDR_W | Byte address of the pending request |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | 8 | Byte returned by the reader |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| rel_o | output | 16 | Device release number |
| attr_o | output | 8 | Configuration attributes |
| max_pwr_o | output | 8 | Maximum power value |
| img_valid_o | output | 1 | 1 when the fields come from the external image |
| ready_o | output | 1 | Loading finished; gates USB attach |

## Verification
The assertions check the following on every cycle: the request handshake discipline, meaning the held address, single-step address increments and the address ceiling; the per-request wait bound; early termination after a bad byte 0; the defaults whenever the image is rejected; and the freezing of all outputs once ready is high. Only the bench's scenarios can show that the captured fields map to the correct byte positions and byte order. The same holds for the exact number of reads taken before an abort, a timeout partway through the image falling back cleanly to defaults, a stray acknowledge being ignored, and a reset during loading restarting detection against new memory contents.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SIG_BYTES   = 2;
  localparam int unsigned FIRST_FIELD = 2;
  localparam int unsigned LAST_BYTE   = 9;
  localparam int unsigned N_FIELD     = LAST_BYTE - FIRST_FIELD + 1;

  localparam logic [15:0] SIG_WORD = 16'h067B;
  localparam logic [15:0] DEF_VID  = 16'h067B;
  localparam logic [15:0] DEF_PID  = 16'h2507;
  localparam logic [15:0] DEF_REL  = 16'h0100;
  localparam logic [7:0]  DEF_ATTR = 8'hC0;
  localparam logic [7:0]  DEF_PWR  = 8'h32;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_DONE = 1'b1
  } ld_state_e;
endpackage

// File: rtl/cfg_boot_sig.sv
module cfg_boot_sig
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              mismatch_o
);
  logic [SIG_BYTES-1:0] byte_bad;

  for (genvar j = 0; j < SIG_BYTES; j++) begin : g_sig
    assign byte_bad[j] = (addr_i == ADDR_W'(j)) &&
                         (data_i != SIG_WORD[j*BYTE_W +: BYTE_W]);
  end

  assign mismatch_o = |byte_bad;
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TMO_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ack_i,
  input  logic              sig_bad_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              cap_o,
  output logic              commit_o,
  output logic              ready_o,
  output logic              valid_o
);
  localparam int unsigned TMO_W = $clog2(TMO_CYCLES + 1);

  ld_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [TMO_W-1:0]  wait_q, wait_d;
  logic              valid_q, valid_d;
  logic              hs, last;

  assign rd_req_o  = (state_q == ST_LOAD);
  assign rd_addr_o = addr_q;
  assign ready_o   = (state_q == ST_DONE);
  assign valid_o   = valid_q;

  assign hs       = rd_req_o && rd_ack_i;
  assign last     = (addr_q == ADDR_W'(LAST_BYTE));
  assign cap_o    = hs;
  assign commit_o = hs && !sig_bad_i && last;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wait_d  = wait_q;
    valid_d = valid_q;
    if (state_q == ST_LOAD) begin
      if (hs) begin
        wait_d = '0;
        if (sig_bad_i) begin
          state_d = ST_DONE;
          valid_d = 1'b0;
        end else if (last) begin
          state_d = ST_DONE;
          valid_d = 1'b1;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end else if (wait_q == TMO_W'(TMO_CYCLES - 1)) begin
        // reader silent: treat memory as absent
        state_d = ST_DONE;
        valid_d = 1'b0;
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      addr_q  <= '0;
      wait_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wait_q  <= wait_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/cfg_boot_regs.sv
module cfg_boot_regs
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              commit_i,
  output logic [15:0]       vid_o,
  output logic [15:0]       pid_o,
  output logic [15:0]       rel_o,
  output logic [7:0]        attr_o,
  output logic [7:0]        max_pwr_o
);
  // image bytes FIRST_FIELD..LAST_BYTE, byte FIRST_FIELD in the low lane
  logic [N_FIELD*BYTE_W-1:0] img_w;

  for (genvar b = 0; b < N_FIELD; b++) begin : g_byte
    logic              hit;
    logic [BYTE_W-1:0] stage_q;

    assign hit = cap_i && (addr_i == ADDR_W'(b + FIRST_FIELD));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  stage_q <= '0;
      else if (hit) stage_q <= data_i;
    end

    // the final byte is committed in the cycle it arrives
    assign img_w[b*BYTE_W +: BYTE_W] = hit ? data_i : stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o     <= DEF_VID;
      pid_o     <= DEF_PID;
      rel_o     <= DEF_REL;
      attr_o    <= DEF_ATTR;
      max_pwr_o <= DEF_PWR;
    end else if (commit_i) begin
      vid_o     <= img_w[15:0];
      pid_o     <= img_w[31:16];
      rel_o     <= img_w[47:32];
      attr_o    <= img_w[55:48];
      max_pwr_o <= img_w[63:56];
    end
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TMO_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic [15:0]       vid_o,
  output logic [15:0]       pid_o,
  output logic [15:0]       rel_o,
  output logic [7:0]        attr_o,
  output logic [7:0]        max_pwr_o,
  output logic              img_valid_o,
  output logic              ready_o
);
  logic sig_bad, cap, commit;

  cfg_boot_sig #(.ADDR_W(ADDR_W)) u_sig (
    .addr_i     (rd_addr_o),
    .data_i     (rd_data_i),
    .mismatch_o (sig_bad)
  );

  cfg_boot_seq #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_ack_i  (rd_ack_i),
    .sig_bad_i (sig_bad),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .cap_o     (cap),
    .commit_o  (commit),
    .ready_o   (ready_o),
    .valid_o   (img_valid_o)
  );

  cfg_boot_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .addr_i    (rd_addr_o),
    .data_i    (rd_data_i),
    .commit_i  (commit),
    .vid_o     (vid_o),
    .pid_o     (pid_o),
    .rel_o     (rel_o),
    .attr_o    (attr_o),
    .max_pwr_o (max_pwr_o)
  );
endmodule

// File: rtl/cfg_boot_chk.sv
module cfg_boot_chk
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TMO_CYCLES = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic [7:0]        rd_data_i,
  input logic [15:0]       vid_o,
  input logic [15:0]       pid_o,
  input logic [15:0]       rel_o,
  input logic [7:0]        attr_o,
  input logic [7:0]        max_pwr_o,
  input logic              img_valid_o,
  input logic              ready_o
);
  localparam int unsigned CW = $clog2(TMO_CYCLES + 1) + 1;
  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wcnt_q <= '0;
    else if (rd_req_o && !rd_ack_i) wcnt_q <= wcnt_q + 1'b1;
    else                            wcnt_q <= '0;
  end

  a_r2_addr_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o <= ADDR_W'(LAST_BYTE));

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> ready_o || (rd_req_o && $stable(rd_addr_o)));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> ready_o || (rd_addr_o == $past(rd_addr_o) + 1'b1));

  a_r3_early_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && rd_addr_o == '0 && rd_data_i != SIG_WORD[7:0]
    |=> ready_o && !img_valid_o);

  a_r5_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !img_valid_o |-> vid_o == DEF_VID && pid_o == DEF_PID &&
    rel_o == DEF_REL && attr_o == DEF_ATTR && max_pwr_o == DEF_PWR);

  a_r6_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> wcnt_q < CW'(TMO_CYCLES));

  a_r7_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r7_no_req_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !rd_req_o);

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable({vid_o, pid_o, rel_o, attr_o, max_pwr_o, img_valid_o}));

  a_r7_valid_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_valid_o |-> ready_o);
endmodule

bind cfg_boot_loader cfg_boot_chk #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_chk (.*);

// File: tb/sim_cfg_boot_loader.sv
`timescale 1ns/1ps
module sim_cfg_boot_loader;
  localparam int unsigned TMO = 32;
  localparam int unsigned NV  = 8;
  // {sig, vid, pid, rel, attr, pwr, latency, stop_at(15 = never stops)}
  localparam logic [87:0] VECS [NV] = '{
    {16'h067B, 16'h1234, 16'hABCD, 16'h0201, 8'h80, 8'hFA, 4'd0,  4'hF},
    {16'h067B, 16'hFFFF, 16'h0000, 16'h9999, 8'h40, 8'h01, 4'd5,  4'hF},
    {16'h0600, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 4'd1,  4'hF},
    {16'h077B, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 4'd2,  4'hF},
    {16'h067B, 16'h5A5A, 16'hA5A5, 16'h0F0F, 8'h11, 8'h22, 4'd0,  4'h0},
    {16'h067B, 16'hBEEF, 16'hCAFE, 16'h0305, 8'hE0, 8'h64, 4'd3,  4'h6},
    {16'h067B, 16'h0102, 16'h0304, 16'h0506, 8'h07, 8'h08, 4'd15, 4'hF},
    {16'h7B06, 16'h0102, 16'h0304, 16'h0506, 8'h07, 8'h08, 4'd0,  4'hF}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_req, rd_ack = 1'b0, img_valid, ready;
  logic [7:0]  rd_addr, rd_data = 8'h00, attr, max_pwr;
  logic [15:0] vid, pid, rel;

  logic [7:0]  mem [16];
  int          lat = 0, stop_at = 15, cnt = 0, n_acks = 0, max_addr = 0;
  logic        resp_en = 1'b1;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cfg_boot_loader #(.ADDR_W(8), .TMO_CYCLES(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .vid_o(vid), .pid_o(pid),
    .rel_o(rel), .attr_o(attr), .max_pwr_o(max_pwr),
    .img_valid_o(img_valid), .ready_o(ready)
  );

  // memory reader model: one-cycle ack after `lat` waiting cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        cnt = 0;
      end else if (rst_ni && resp_en && rd_req && int'(rd_addr) < stop_at) begin
        if (cnt >= lat) begin
          rd_ack  = 1'b1;
          rd_data = mem[rd_addr[3:0]];
          n_acks++;
          if (int'(rd_addr) > max_addr) max_addr = int'(rd_addr);
        end else cnt++;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {vid, pid, rel, attr, max_pwr};
  endfunction

  task automatic load_mem(input logic [87:0] v);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mem[0] = v[79:72]; mem[1] = v[87:80];
    mem[2] = v[63:56]; mem[3] = v[71:64];
    mem[4] = v[47:40]; mem[5] = v[55:48];
    mem[6] = v[31:24]; mem[7] = v[39:32];
    mem[8] = v[23:16]; mem[9] = v[15:8];
    lat = int'(v[7:4]);
    stop_at = int'(v[3:0]);
  endtask

  task automatic do_reset(input bit chk_r1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rd_ack = 1'b0; cnt = 0; n_acks = 0; max_addr = 0;
    @(negedge clk);
    if (chk_r1) begin
      check("R1 reset ready/valid/req", {62'd0, ready, img_valid}, 64'd0);
      check("R1 reset req addr", {55'd0, rd_req, rd_addr}, {55'd0, 1'b1, 8'd0});
      check("R1 reset defaults", outs(),
            {16'h067B, 16'h2507, 16'h0100, 8'hC0, 8'h32});
    end
    rst_ni = 1'b1;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(input logic [87:0] v);
    logic [15:0] sig;
    logic        ev;
    int          en;
    logic [63:0] snap;
    sig = v[87:72];
    ev  = (sig == 16'h067B) && (v[3:0] > 4'd9);
    en  = (sig[7:0] != 8'h7B) ? 1 : (sig[15:8] != 8'h06) ? 2 : 10;
    if (int'(v[3:0]) < en) en = int'(v[3:0]);
    check("R7 ready after load", {63'd0, ready}, 64'd1);
    check("R4/R5 valid flag", {63'd0, img_valid}, {63'd0, ev});
    if (ev) check("R4 image fields", outs(), v[71:8]);
    else    check("R5/R6 default fields", outs(),
                  {16'h067B, 16'h2507, 16'h0100, 8'hC0, 8'h32});
    check("R3/R6 read count", 64'(n_acks), 64'(en));
    check("R2 max address", 64'(max_addr <= 9), 64'd1);
    snap = outs();
    repeat (5) @(negedge clk);
    check("R7 frozen outputs", outs(), snap);
    check("R7 no request when ready", {62'd0, rd_req, ready}, 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    for (int k = 0; k < NV; k++) begin
      load_mem(VECS[k]);
      do_reset(k == 0);
      wait_ready();
      check_result(VECS[k]);
    end

    // R8: stray ack while idle
    load_mem(VECS[0]);
    do_reset(1'b0);
    wait_ready();
    resp_en = 1'b0;
    @(negedge clk);
    rd_ack = 1'b1; rd_data = 8'h55;
    @(negedge clk);
    @(negedge clk);
    check("R8 stray ack ignored", outs(), VECS[0][71:8]);
    check("R8 flags after stray ack", {62'd0, ready, img_valid}, 64'd3);
    resp_en = 1'b1;

    // R9: reset mid-load, then new contents
    load_mem({16'h067B, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 4'd10, 4'hF});
    do_reset(1'b0);
    repeat (25) @(negedge clk);
    check("R7 ready low mid-load", {63'd0, ready}, 64'd0);
    load_mem(VECS[1]);
    do_reset(1'b0);
    wait_ready();
    check("R9 reload after mid reset", outs(), VECS[1][71:8]);
    check("R9 reread from zero", 64'(n_acks), 64'd10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule